// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets a bus host read and write a bank of 16-bit registers. It watches SCL and SDA through a system clock that runs many times faster than the bus. From that view it recognises START, repeated START and STOP conditions. It answers a family of four device addresses. After the device address, a host sends a two-byte register pointer and then either writes 16-bit words or reads them back. Each word travels high byte first.

The pointer lives inside the target and is shown on a simple register-file port. The bank is outside the block. It returns read data combinationally for the address presented, and it accepts a one-cycle write strobe. A read can follow the pointer bytes directly after a repeated START. It can also come as a separate transaction after a STOP, in which case it uses the pointer left by an earlier pointer-only write. Sequential words move the pointer forward by one per word. The target never drives SDA high: it only asserts an enable that pulls the line low. SCL is never held low (no clock stretching).

Top module: `i2c_reg_target`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state. A rising SDA while SCL is high (STOP) returns the target to idle with SDA released. A word that is cut off by a STOP is not written. After reset, sda_oe and reg_we are 0 and reg_addr is 0.
- R2: The target acknowledges a device-address byte whose upper five address bits are 0,1,0,1,1. The two lowest address bits may take any value. On the wire the address byte is {5'b01011, two free bits, R/W}.
- R3: On any other device address, the target does not acknowledge, writes nothing and leaves SDA released for every following byte, until the next START.
- R4: An R/W bit (bit 0 of the address byte) of 0 selects a write transaction. A value of 1 selects a read transaction.
- R5: In a write, the next two bytes form the register pointer, upper byte first. Only bits 9:0 are used; bits 15:10 are ignored. The target pulls SDA low in the ninth clock after each pointer byte and after each data byte.
- R6: Write data follows the pointer as 16-bit words, high byte first. After each second byte, reg_we pulses for exactly one clk cycle, with reg_wdata holding the word and reg_addr holding the pointer.
- R7: In a read, the target shifts out the word reg_rdata at reg_addr, high byte first and most significant bit first.
- R8: A read works both after a repeated START that follows the pointer bytes, and in a separate transaction after a STOP that follows a pointer-only write.
- R9: The pointer advances by one after each complete word written or read, wrapping from 1023 to 0.
- R10: If the host does not acknowledge a read byte, the readback ends and SDA stays released until the next START or STOP.
- R11: sda_oe only pulls SDA low, and it changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| reg_addr | output | 10 | Current register pointer presented to the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Word to store at reg_addr when reg_we is 1 |
| reg_rdata | input | 16 | Bank contents at reg_addr (combinational) |

## Verification
On every cycle, the assertions check four things. SDA output changes only while SCL is low. The write strobe is a single-cycle pulse, and the pointer steps by one right after it. The target stays silent, neither pulling SDA nor writing, while it is idle or ignoring the bus. It holds SDA low through the acknowledge clock. Other behaviours need whole bus transactions and only the bench scenarios can show them. These are address matching across the four aliases, the order of pointer and data bytes, combined and split reads, wrapping at the top of the pointer range, a STOP that cuts off a half word, and the release after a host not-acknowledge.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the I2C register-access target.
// Assumes 8-bit bus bytes and 16-bit register words (two bytes per word).
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Bus-level state of the protocol engine.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte from the host
        ST_ACK,    // driving our acknowledge bit
        ST_TX,     // shifting out a read byte
        ST_MACK,   // sampling the host's acknowledge
        ST_SKIP    // not addressed or readback ended: ignore until START/STOP
    } state_t;

    // Which byte of the transfer is being received.
    typedef enum logic [2:0] {
        PH_DEV,    // device address + R/W
        PH_PHI,    // pointer upper byte
        PH_PLO,    // pointer lower byte
        PH_DHI,    // data high byte
        PH_DLO     // data low byte
    } phase_t;

endpackage

// File: rtl/i2c_tgt_sampler.sv
// Bus line conditioner: synchronises SCL and SDA to clk and derives
// one-cycle SCL edge strobes and START/STOP conditions.
// Assumes clk is fast enough that each SCL level lasts several clk cycles.
module i2c_tgt_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_p;
    logic                   sda_p;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            // Single flop per line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= 1'b1;
                    sda_chain <= 1'b1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_syncn
            // Shift chain per line, idle-high reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
// Protocol engine: device-address match, pointer capture, word writes,
// word readback and pointer advance. It acts only on the conditioned
// strobes from the sampler. Assumes the strobes are at least a few clk
// cycles apart and that the bank answers reg_rdata for reg_addr
// combinationally.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int         ADDR_W     = 10,
    parameter logic [4:0] DEV_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata
);

    localparam int HI_W = ADDR_W - BYTE_W;

    state_t              state;
    phase_t              phase;
    logic [3:0]          bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   rx_byte;
    logic [HI_W-1:0]     ptr_hi;
    logic [ADDR_W-1:0]   ptr;
    logic [BYTE_W-1:0]   wr_hi;
    logic [WORD_W-1:0]   tx_word;
    logic                is_read;
    logic                tx_lo;
    logic                half;
    logic                host_ack;

    assign rx_byte  = {shreg[BYTE_W-2:0], sda_s};
    assign reg_addr = ptr;

    // Main bus sequencer: one transition per SCL strobe or bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_DEV;
            bit_cnt   <= '0;
            shreg     <= '0;
            ptr_hi    <= '0;
            ptr       <= '0;
            wr_hi     <= '0;
            tx_word   <= '0;
            is_read   <= 1'b0;
            tx_lo     <= 1'b0;
            half      <= 1'b0;
            host_ack  <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (reg_we) ptr <= ptr + 1'b1;
            if (start_ev) begin
                state   <= ST_RX;
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                half    <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                half   <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: if (scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                            state   <= ST_ACK;
                            unique case (phase)
                                PH_DEV: begin
                                    is_read <= rx_byte[0];
                                    if (rx_byte[7:3] != DEV_PREFIX) state <= ST_SKIP;
                                end
                                PH_PHI: ptr_hi <= rx_byte[HI_W-1:0];
                                PH_PLO: ptr    <= {ptr_hi, rx_byte};
                                PH_DHI: wr_hi  <= rx_byte;
                                PH_DLO: begin
                                    reg_we    <= 1'b1;
                                    reg_wdata <= {wr_hi, rx_byte};
                                end
                                default: state <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!half) begin
                            sda_oe <= 1'b1;
                            half   <= 1'b1;
                        end else begin
                            half <= 1'b0;
                            if (phase == PH_DEV && is_read) begin
                                state   <= ST_TX;
                                tx_word <= reg_rdata;
                                tx_lo   <= 1'b0;
                                sda_oe  <= ~reg_rdata[WORD_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                                unique case (phase)
                                    PH_DEV:  phase <= PH_PHI;
                                    PH_PHI:  phase <= PH_PLO;
                                    PH_PLO:  phase <= PH_DHI;
                                    PH_DHI:  phase <= PH_DLO;
                                    default: phase <= PH_DHI;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            tx_word <= tx_word << 1;
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                                half   <= 1'b0;
                            end else begin
                                sda_oe <= ~tx_word[WORD_W-1];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                            half     <= 1'b1;
                            if (tx_lo) ptr <= ptr + 1'b1;
                        end else if (scl_fall && half) begin
                            half    <= 1'b0;
                            bit_cnt <= '0;
                            if (!host_ack) begin
                                state <= ST_SKIP;
                            end else if (!tx_lo) begin
                                tx_lo  <= 1'b1;
                                state  <= ST_TX;
                                sda_oe <= ~tx_word[WORD_W-1];
                            end else begin
                                tx_lo   <= 1'b0;
                                tx_word <= reg_rdata;
                                state   <= ST_TX;
                                sda_oe  <= ~reg_rdata[WORD_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the pull-down only moves while SCL is low.
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R6: a write strobe lasts one cycle.
    a_r6_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R9: the pointer steps by one right after a word write.
    a_r9_ptr_step_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + 1'b1));

    // R3: silent while idle or ignoring the bus.
    a_r3_quiet_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> (!sda_oe && !reg_we));

    // R5: during the acknowledge clock the line is held low.
    a_r5_ack_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && half) |-> sda_oe);

endmodule

// File: rtl/i2c_reg_target.sv
// Top of the I2C register-access target: line conditioner plus protocol
// engine. Assumes an external open-drain pad (sda_oe pulls low) and a
// register bank with combinational read data.
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         ADDR_W      = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_PREFIX  = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    i2c_tgt_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sampler_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_tgt_engine #(
        .ADDR_W     (ADDR_W),
        .DEV_PREFIX (DEV_PREFIX)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: tb/i2c_reg_target_tb_top.sv
// Bench: bit-banged bus host, behavioural register bank, vector table
// walk followed by directed corner cases.
module i2c_reg_target_tb_top;

    localparam int HALF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [9:0]  reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        sda_line;
    logic [15:0] bank [1024];
    int          checks = 0;
    int          errors = 0;
    int          wr_count = 0;
    int          r11_viol = 0;
    logic        prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_reg_target dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [15:0] seed(int idx);
        return 16'h5A00 ^ 16'(idx);
    endfunction

    // Behavioural bank with a known power-up pattern.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) bank[i] <= seed(i);
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // R11 monitor: pull-down must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) r11_viol <= r11_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
        end
        sda_m = 1'b1; hp(); scl_m = 1'b1;
        repeat (HALF / 2) @(negedge clk);
        ack = ~sda_line;
        repeat (HALF / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl_m = 1'b1;
            repeat (HALF / 2) @(negedge clk);
            b[i] = sda_line;
            repeat (HALF / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = nack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic [1:0] lo, input logic rd);
        return {5'b01011, lo, rd};
    endfunction

    // START, device write, two pointer bytes with junk in bits 15:10.
    task automatic set_ptr(input logic [1:0] lo, input logic [9:0] a, output logic ok);
        logic k0, k1, k2;
        bus_start();
        send_byte(dev_byte(lo, 1'b0), k0);
        send_byte({6'b101101, a[9:8]}, k1);
        send_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic send_word(input logic [15:0] w, output logic ok);
        logic k0, k1;
        send_byte(w[15:8], k0);
        send_byte(w[7:0], k1);
        ok = k0 & k1;
    endtask

    task automatic recv_word(input logic last, output logic [15:0] w);
        logic [7:0] h, l;
        recv_byte(1'b0, h);
        recv_byte(last, l);
        w = {h, l};
    endtask

    // {device low bits, pointer, data}
    localparam logic [27:0] VEC [6] = '{
        {2'b00, 10'h000, 16'h1234},
        {2'b01, 10'h3FF, 16'hBEEF},
        {2'b10, 10'h155, 16'h0000},
        {2'b11, 10'h2AA, 16'hFFFF},
        {2'b01, 10'h001, 16'h8001},
        {2'b10, 10'h300, 16'h5A3C}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        logic        ok, ak;
        logic [15:0] w;
        logic [7:0]  b;
        int          wc;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset sda_oe", 32'(sda_oe), 32'd0);
        chk("R1 reset reg_we", 32'(reg_we), 32'd0);
        chk("R1 reset reg_addr", 32'(reg_addr), 32'd0);

        // Vector walk: R2 aliases, R4/R5/R6 write, R7/R8 combined read.
        for (int v = 0; v < 6; v++) begin
            set_ptr(VEC[v][27:26], VEC[v][25:16], ok);
            send_word(VEC[v][15:0], ak);
            bus_stop();
            chk("R2 R5 acks on write", 32'(ok & ak), 32'd1);
            chk("R6 word stored", 32'(bank[VEC[v][25:16]]), 32'(VEC[v][15:0]));
            set_ptr(VEC[v][27:26], VEC[v][25:16], ok);
            bus_rstart();
            send_byte(dev_byte(VEC[v][27:26], 1'b1), ak);
            recv_word(1'b1, w);
            bus_stop();
            chk("R4 R8 read acks", 32'(ok & ak), 32'd1);
            chk("R7 readback", 32'(w), 32'(VEC[v][15:0]));
        end

        // R9: sequential write across the top of the pointer range.
        set_ptr(2'b00, 10'h3FE, ok);
        send_word(16'hA0A1, ak);
        send_word(16'hB0B1, ak);
        send_word(16'hC0C1, ak);
        bus_stop();
        chk("R9 write 0x3FE", 32'(bank[10'h3FE]), 32'h0000A0A1);
        chk("R9 write 0x3FF", 32'(bank[10'h3FF]), 32'h0000B0B1);
        chk("R9 write wraps to 0", 32'(bank[10'h000]), 32'h0000C0C1);

        // R8 split read with R9 wrap on the read side.
        set_ptr(2'b11, 10'h3FF, ok);
        bus_stop();
        bus_start();
        send_byte(dev_byte(2'b10, 1'b1), ak);
        recv_word(1'b0, w);
        chk("R8 split read word0", 32'(w), 32'h0000B0B1);
        recv_word(1'b1, w);
        bus_stop();
        chk("R9 read wraps to 0", 32'(w), 32'h0000C0C1);

        // R3: foreign address, then bytes that must be ignored.
        wc = wr_count;
        bus_start();
        send_byte(8'b0110_0000, ak);
        chk("R3 no ack on foreign address", 32'(ak), 32'd0);
        send_byte(8'h00, ok); ak = ok;
        send_byte(8'h10, ok); ak = ak | ok;
        send_byte(8'h12, ok); ak = ak | ok;
        send_byte(8'h34, ok); ak = ak | ok;
        chk("R3 ignored bytes not acked", 32'(ak), 32'd0);
        chk("R3 nothing written", 32'(wr_count), 32'(wc));
        // R1: repeated START recovers from the ignore state.
        bus_rstart();
        send_byte(dev_byte(2'b00, 1'b0), ok);
        send_byte(8'h02, ak); ok = ok & ak;
        send_byte(8'hAA, ak); ok = ok & ak;
        bus_rstart();
        send_byte(dev_byte(2'b00, 1'b1), ak);
        recv_word(1'b1, w);
        bus_stop();
        chk("R1 START after ignore acks", 32'(ok & ak), 32'd1);
        chk("R1 read after recovery", 32'(w), 32'h0000FFFF);

        // R10: NACK on the high byte ends the readback.
        set_ptr(2'b01, 10'h300, ok);
        bus_rstart();
        send_byte(dev_byte(2'b01, 1'b1), ak);
        recv_byte(1'b1, b);
        chk("R10 high byte before NACK", 32'(b), 32'h0000005A);
        recv_byte(1'b1, b);
        chk("R10 SDA released after NACK", 32'(b), 32'h000000FF);
        bus_stop();
        chk("R10 pull-down off after STOP", 32'(sda_oe), 32'd0);

        // R1: STOP in the middle of a word writes nothing.
        wc = wr_count;
        set_ptr(2'b00, 10'h010, ok);
        send_byte(8'hEE, ak);
        bus_stop();
        chk("R1 cut word not written", 32'(wr_count), 32'(wc));
        bus_start();
        send_byte(dev_byte(2'b00, 1'b1), ak);
        recv_word(1'b1, w);
        bus_stop();
        chk("R1 R8 pointer kept after STOP", 32'(w), 32'(seed(16)));

        // R11: accumulated from the monitor.
        chk("R11 no SDA change while SCL high", 32'(r11_viol), 32'd0);

        summary();
        $finish;
    end

endmodule